// File: doc/BRIEF.md
# DMA Channel Enable and Request Routing Controller

This block is the control plane for four DMA channels, numbered 0 to 3 inside the design and called 0A, 0B, 1A and 1B in software terms (index 0 = 0A, 1 = 0B, 2 = 1A, 3 = 1B). Each channel has a transfer-enable bit. Software can set this bit only under a guard. The hardware clears it on abort, and it also clears it when the transfer count runs out outside repeat mode. The enable bit steers every activation request. When a channel is enabled, its requests are queued for a data mover behind a start/done handshake. When a channel is disabled, a request from an internal-interrupt source goes straight to the CPU interrupt line.

A small register port holds the enable bits, the per-channel end-of-transfer interrupt enables and one acknowledge-control bit for channel 0A. Each channel has a transfer counter. A load strobe programs it, and a repeat flag decides what happens when the count reaches zero. The block picks one pending channel at a time by fixed priority and starts it. It then waits for the done pulse before it starts the next.

Top module: `dmac_chan_ctl`

## Requirements
- R1: After reset, every register bit reads 0, no channel is enabled, and xfer_start, src_flag_clr, irq_cpu and tend_irq are all 0.
- R2: The register layout is as follows. Bit 8 is the channel-0 acknowledge control. Bits 7 down to 4 are the enable bits of channels 3, 2, 1 and 0. Bits 3 down to 0 are the end-interrupt enables of channels 3, 2, 1 and 0. Bits 15 to 9 read as 0 whatever is written.
- R3: Writing 1 to a clear enable bit sets it only if a read since the most recent write returned that bit as 0. Otherwise the write leaves the bit at 0. Every write disarms all channels. Writing 1 to an enable bit that is already 1 keeps it at 1.
- R4: Writing 0 to an enable bit clears it at once (forced abort).
- R5: Outside repeat mode, a channel loaded with a count of N clears its own enable bit when its N-th transfer completes. The bit stays 1 after each earlier transfer.
- R6: In repeat mode, the counter reloads its programmed value when the count expires, and the enable bit stays 1 across any number of transfers.
- R7: A request on a disabled channel never starts a transfer. If that channel's source is an internal interrupt, irq_cpu for the channel follows req_in in the same cycle. A request on an enabled channel does not reach irq_cpu.
- R8: tend_irq for a channel is 1 exactly while its enable bit is 0 and its end-interrupt enable is 1.
- R9: When several channels are pending together, they are served in the order 0, 1, 2, 3. A new start is never issued while a transfer is outstanding.
- R10: When the acknowledge-control bit is 1, completing a channel-0 transfer pulses src_flag_clr for one cycle. When the bit is 0, no pulse is produced.
- R11: A request sampled on an enabled, idle channel at clock edge k produces a one-cycle xfer_start, carrying the channel index on xfer_ch, after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the set guard) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| req_in | input | NCH | Per-channel activation request |
| src_is_int | input | NCH | Per-channel flag: source is an internal interrupt |
| irq_cpu | output | NCH | Request forwarded to the CPU as an interrupt |
| cfg_load | input | NCH | Per-channel counter load strobe |
| cfg_count | input | CW | Count value for cfg_load |
| rpt_mode | input | NCH | Per-channel repeat-mode flag |
| xfer_start | output | 1 | One-cycle start pulse to the data mover |
| xfer_ch | output | CHW | Channel index of the current transfer |
| xfer_done | input | 1 | Completion pulse from the data mover |
| src_flag_clr | output | 1 | One-cycle clear of the channel-0 source flag |
| tend_irq | output | NCH | Per-channel transfer-end interrupt |

## Verification
The hardest case to reach is the set guard. Setting a bit needs a read that returns 0, followed by a write, with no other write in between. Any other write disarms the channel again, so the failing orderings need deliberate sequences. The stimulus covers a write of 1 with no read before it, and a write of 1 after a read that has been spoiled by an intervening write. It also covers the good read-then-write order, and writes that keep an already-set bit at 1. Hardware self-clearing is reached by loading small counts and completing exactly that many handshakes. In repeat mode, the bench completes more transfers than the loaded count.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
    localparam int REG_W   = 16;
    localparam int ACK_BIT = 8;
    localparam int EN_LSB  = 4;
    localparam int TIE_LSB = 0;
endpackage

// File: rtl/dmac_xfer_cnt.sv
module dmac_xfer_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic          rpt,
    output logic          last,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] init;
    } cnt_st_t;

    cnt_st_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (load) begin
            cs_d.cnt  = load_val;
            cs_d.init = load_val;
        end else if (dec) begin
            if (cs_q.cnt == CW'(1) && rpt) cs_d.cnt = cs_q.init;
            else                           cs_d.cnt = cs_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign last  = (cs_q.cnt == CW'(1));
    assign count = cs_q.cnt;

    // R6: an expiring repeat counter comes back with its programmed value
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && last && rpt && !load) |=> (count == $past(cs_q.init)));
endmodule

// File: rtl/dmac_prio.sv
module dmac_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         hit
);
    always_comb begin
        gnt = '0;
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !hit) begin
                gnt[i] = 1'b1;
                hit    = 1'b1;
            end
        end
    end

    // R9: at most one channel is granted
    always_comb p_gnt_onehot_r9: assert ($onehot0(gnt));
endmodule

// File: rtl/dmac_chan_ctl.sv
module dmac_chan_ctl
    import dmac_ctl_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NCH-1:0]   req_in,
    input  logic [NCH-1:0]   src_is_int,
    output logic [NCH-1:0]   irq_cpu,
    input  logic [NCH-1:0]   cfg_load,
    input  logic [CW-1:0]    cfg_count,
    input  logic [NCH-1:0]   rpt_mode,
    output logic             xfer_start,
    output logic [CHW-1:0]   xfer_ch,
    input  logic             xfer_done,
    output logic             src_flag_clr,
    output logic [NCH-1:0]   tend_irq
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] arm;
        logic [NCH-1:0] tie;
        logic           ack;
        logic [NCH-1:0] pend;
        logic           busy;
        logic [CHW-1:0] cur;
        logic           start;
        logic           flagclr;
    } ctl_st_t;

    ctl_st_t        st_d, st_q;
    logic [NCH-1:0] dec_d;
    logic [NCH-1:0] last_q;
    logic [NCH-1:0] gnt;
    logic           gnt_hit;
    logic [CHW-1:0] gnt_idx;
    logic           unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:ACK_BIT+1];

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_cnt
            logic [CW-1:0] unused_count;
            dmac_xfer_cnt #(.CW(CW)) i_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (cfg_load[g]),
                .load_val (cfg_count),
                .dec      (dec_d[g]),
                .rpt      (rpt_mode[g]),
                .last     (last_q[g]),
                .count    (unused_count)
            );
        end
    endgenerate

    dmac_prio #(.N(NCH)) i_prio (
        .req (st_q.pend & st_q.en),
        .gnt (gnt),
        .hit (gnt_hit)
    );

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < NCH; i++)
            if (gnt[i]) gnt_idx = CHW'(i);
    end

    always_comb begin
        st_d         = st_q;
        st_d.start   = 1'b0;
        st_d.flagclr = 1'b0;
        dec_d        = '0;

        // completion: count down, self-clear outside repeat mode
        if (st_q.busy && xfer_done) begin
            st_d.busy          = 1'b0;
            dec_d[st_q.cur]    = 1'b1;
            if (last_q[st_q.cur] && !rpt_mode[st_q.cur])
                st_d.en[st_q.cur] = 1'b0;
            if (st_q.cur == '0 && st_q.ack)
                st_d.flagclr = 1'b1;
        end

        // launch the highest-priority pending channel
        if (!st_q.busy && gnt_hit) begin
            st_d.busy          = 1'b1;
            st_d.start         = 1'b1;
            st_d.cur           = gnt_idx;
            st_d.pend[gnt_idx] = 1'b0;
        end

        // capture requests of enabled channels
        for (int i = 0; i < NCH; i++)
            if (st_q.en[i] && req_in[i]) st_d.pend[i] = 1'b1;

        // register access: write wins and disarms, read of 0 arms
        if (reg_wr) begin
            for (int i = 0; i < NCH; i++) begin
                if (!reg_wdata[EN_LSB+i])  st_d.en[i] = 1'b0;
                else if (st_q.arm[i])      st_d.en[i] = 1'b1;
            end
            st_d.arm = '0;
            st_d.tie = reg_wdata[TIE_LSB +: NCH];
            st_d.ack = reg_wdata[ACK_BIT];
        end else if (reg_rd) begin
            for (int i = 0; i < NCH; i++)
                if (!st_q.en[i]) st_d.arm[i] = 1'b1;
        end

        st_d.pend = st_d.pend & st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[ACK_BIT]           = st_q.ack;
        reg_rdata[EN_LSB +: NCH]     = st_q.en;
        reg_rdata[TIE_LSB +: NCH]    = st_q.tie;
    end

    assign irq_cpu      = req_in & src_is_int & ~st_q.en;
    assign tend_irq     = st_q.tie & ~st_q.en;
    assign xfer_start   = st_q.start;
    assign xfer_ch      = st_q.cur;
    assign src_flag_clr = st_q.flagclr;

    // R9: a start pulse lasts one cycle and needs an idle engine before it
    p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !$past(st_q.busy));
    p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    generate
        for (g = 0; g < NCH; g++) begin : g_chk
            // R3: a 0->1 change of the enable bit needs a prior arming read
            p_set_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(st_q.en[g]) && st_q.en[g]) |-> $past(st_q.arm[g]));
            // R7: a started channel was enabled one cycle before
            p_start_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_start && xfer_ch == CHW'(g)) |-> $past(st_q.en[g]));
            // R5: last transfer outside repeat mode drops the enable
            p_count_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.busy && xfer_done && st_q.cur == CHW'(g) && last_q[g]
                 && !rpt_mode[g] && !reg_wr) |=> !st_q.en[g]);
        end
    endgenerate
endmodule

// File: tb/test_dmac_chan_ctl.sv
module test_dmac_chan_ctl;
    localparam int NCH = 4;
    localparam int CW  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [3:0]  req_in = '0, src_is_int = '0, irq_cpu;
    logic [3:0]  cfg_load = '0, rpt_mode = '0, tend_irq;
    logic [7:0]  cfg_count = '0;
    logic        xfer_start, xfer_done = 1'b0, src_flag_clr;
    logic [1:0]  xfer_ch;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dmac_chan_ctl #(.NCH(NCH), .CW(CW)) i_dmac_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
        .src_is_int(src_is_int), .irq_cpu(irq_cpu), .cfg_load(cfg_load),
        .cfg_count(cfg_count), .rpt_mode(rpt_mode), .xfer_start(xfer_start),
        .xfer_ch(xfer_ch), .xfer_done(xfer_done), .src_flag_clr(src_flag_clr),
        .tend_irq(tend_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(output logic [15:0] v);
        @(negedge clk); reg_rd = 1'b1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic load(input logic [3:0] m, input logic [7:0] n);
        @(negedge clk); cfg_load = m; cfg_count = n;
        @(negedge clk); cfg_load = '0;
    endtask

    task automatic pulse_req(input logic [3:0] m);
        @(negedge clk); req_in = m;
        @(negedge clk); req_in = '0;
    endtask

    task automatic serve(input int ch, input string tag);
        @(negedge clk);
        chk(xfer_start === 1'b1, {tag, " start"}, int'(xfer_start), 1);
        chk(xfer_ch == 2'(ch), {tag, " channel"}, int'(xfer_ch), ch);
        xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        #1;
        chk(reg_rdata == 16'h0, "R1 regs", int'(reg_rdata), 0);
        chk(xfer_start == 1'b0 && src_flag_clr == 1'b0, "R1 pulses",
            int'({xfer_start, src_flag_clr}), 0);
        chk(tend_irq == 4'h0 && irq_cpu == 4'h0, "R1 irqs", int'({tend_irq, irq_cpu}), 0);
        rd(v);
    endtask

    task automatic t_guard();
        logic [15:0] v;
        wr(16'h0000);                 // disarm whatever reset-time read armed
        wr(16'h0010);                 // R3: write 1 with no read of 0 before it
        rd(v);
        chk(v == 16'h0000, "R3 unguarded set ignored", int'(v), 0);
        wr(16'hFFFF);                 // armed by the read above
        rd(v);
        chk(v == 16'h01FF, "R2 layout readback", int'(v), 16'h01FF);
        wr(16'h0000);
        rd(v);
        chk(v == 16'h0000, "R4 abort all", int'(v), 0);
        wr(16'h0000);                 // spoils the arming read
        wr(16'h0020);
        rd(v);
        chk(v == 16'h0000, "R3 write disarms", int'(v), 0);
        wr(16'h0000);
    endtask

    task automatic t_tend();
        logic [15:0] v;
        wr(16'h000F);
        #1 chk(tend_irq == 4'hF, "R8 all disabled", int'(tend_irq), 4'hF);
        rd(v);
        wr(16'h001F);
        #1 chk(tend_irq == 4'hE, "R8 channel0 enabled", int'(tend_irq), 4'hE);
        wr(16'h001F);                 // R3: 1 onto an already set bit keeps it
        rd(v);
        chk(v == 16'h001F, "R3 keep set", int'(v), 16'h001F);
        wr(16'h000F);
        rd(v);
        chk(v == 16'h000F, "R4 abort channel0", int'(v), 16'h000F);
        chk(tend_irq == 4'hF, "R8 after abort", int'(tend_irq), 4'hF);
        wr(16'h0000);
    endtask

    task automatic t_route();
        logic [15:0] v;
        src_is_int = 4'b1000;
        @(negedge clk); req_in = 4'h8;
        #1 chk(irq_cpu == 4'h8, "R7 disabled to cpu", int'(irq_cpu), 8);
        @(negedge clk); req_in = 4'h0;
        @(negedge clk);
        chk(xfer_start == 1'b0, "R7 no transfer when disabled", int'(xfer_start), 0);
        load(4'h8, 8'd5);
        rd(v); wr(16'h0080);
        @(negedge clk); req_in = 4'h8;
        #1 chk(irq_cpu == 4'h0, "R7 enabled not to cpu", int'(irq_cpu), 0);
        @(negedge clk); req_in = 4'h0;
        serve(3, "R11");
        wr(16'h0000);
        src_is_int = 4'b0000;
    endtask

    task automatic t_count();
        logic [15:0] v;
        load(4'h2, 8'd2);
        rd(v); wr(16'h0020);
        pulse_req(4'h2); serve(1, "R5 first");
        rd(v);
        chk(v[5] == 1'b1, "R5 enabled after first", int'(v[5]), 1);
        pulse_req(4'h2); serve(1, "R5 second");
        rd(v);
        chk(v[5] == 1'b0, "R5 self-clear", int'(v[5]), 0);
        wr(16'h0000);
    endtask

    task automatic t_repeat();
        logic [15:0] v;
        rpt_mode = 4'h4;
        load(4'h4, 8'd1);
        rd(v); wr(16'h0040);
        for (int k = 0; k < 3; k++) begin
            pulse_req(4'h4); serve(2, "R6");
            rd(v);
            chk(v[6] == 1'b1, "R6 stays enabled", int'(v[6]), 1);
        end
        wr(16'h0000);
        rpt_mode = 4'h0;
    endtask

    task automatic t_prio();
        logic [15:0] v;
        load(4'hF, 8'd10);
        rd(v); wr(16'h00F0);
        pulse_req(4'hF);
        serve(0, "R9 order");
        chk(xfer_start == 1'b0, "R9 idle gap", int'(xfer_start), 0);
        serve(1, "R9 order");
        serve(2, "R9 order");
        serve(3, "R9 order");
        @(negedge clk);
        chk(xfer_start == 1'b0, "R9 nothing left", int'(xfer_start), 0);
        wr(16'h0000);
    endtask

    task automatic t_ack();
        logic [15:0] v;
        load(4'h1, 8'd10);
        rd(v); wr(16'h0110);
        pulse_req(4'h1); serve(0, "R10");
        chk(src_flag_clr == 1'b1, "R10 clear pulse", int'(src_flag_clr), 1);
        @(negedge clk);
        chk(src_flag_clr == 1'b0, "R10 single pulse", int'(src_flag_clr), 0);
        wr(16'h0010);
        pulse_req(4'h1); serve(0, "R10");
        chk(src_flag_clr == 1'b0, "R10 no pulse when off", int'(src_flag_clr), 0);
        wr(16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_guard();
        t_tend();
        t_route();
        t_count();
        t_repeat();
        t_prio();
        t_ack();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule